// File: doc/BRIEF.md
# Lockable watchdog reset timer

This block is a watchdog timer for a chip-level reset controller. Software starts it by writing a control word with the start bit set. From then on the count cannot be halted by any write. Each write to the control word clears the count and the prescaler. Software must therefore write again before the programmed period runs out. If it does not, the count reaches its terminal value and the block emits a one-cycle overflow event. In reset-request mode that event is a reset request, and the counter then freezes. It stays frozen until the dedicated watchdog reset is applied. In interrupt mode the event is an interrupt pulse, and counting wraps and continues.

The count advances only on ticks from a built-in prescaler. The prescaler divides the clock by a power of two between 1 and 128. An external count-enable input models a paused tick source, such as a clock source that is gated off in a power-save state. While that input is low, the count and the prescaler keep their values. When it goes high again, counting resumes from where it stopped. The watchdog reset asserts asynchronously and is released synchronously, through a two-stage synchronizer.

Top module: `wdog_timer`

## Requirements
- R1: After the watchdog reset, `rst_req` and `irq` are 0. No event occurs as long as no write sets the start bit.
- R2: The control word has the start bit at bit 0, the mode bit at bit 1 (1 = reset request, 0 = interrupt) and the divider select at bits 4:2. A write with bit 0 set starts counting on the cycle after the write.
- R3: In reset-request mode, an overflow drives `rst_req` high for exactly one cycle. For a write at clock edge W and a divide ratio d, the pulse follows edge W + d·2^CNT_W.
- R4: After a reset request the counter is frozen. No further `rst_req` or `irq` pulse appears until the watchdog reset, including after further control writes.
- R5: Once counting has started, writes that clear bit 0 or that change bit 1 do not stop the counter and do not change the mode.
- R6: Every control write clears the count and the prescaler. Writes spaced closer than the period prevent any overflow.
- R7: A divider select s gives one tick per 2^s enabled clocks (ratios 1 to 128). The select is taken from every write.
- R8: While `cnt_en` is 0, the count and the prescaler hold their values. When `cnt_en` returns to 1, counting continues without reset, so the event is delayed by exactly the number of paused cycles.
- R9: In interrupt mode an overflow gives a one-cycle `irq` pulse, and counting restarts from zero. Successive pulses are d·2^CNT_W cycles apart. `rst_req` and `irq` are never high together.
- R10: Asserting `wd_rst_n` low clears both outputs at once and clears the run state, the mode, the frozen state and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| wd_rst_n | input | 1 | Watchdog system reset, active low, asynchronous assert |
| cnt_en | input | 1 | Tick-source availability; 0 pauses counting |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 5 | Control word: bit 0 start, bit 1 mode, bits 4:2 divider select |
| rst_req | output | 1 | One-cycle reset-request pulse |
| irq | output | 1 | One-cycle interrupt pulse (interrupt mode) |

## Verification
The count, the prescaler phase and the run/mode state are not visible at the ports. They can only be seen through the timing of `rst_req` and `irq`. A wrong value in any of them shows up as an event that comes early, comes late, comes at all when it should not, or comes on the wrong output. The bench compares both outputs against a reference model on every cycle, so any such error shows up no later than one overflow period after it occurs. For a frozen state or a stuck run bit, it shows up within the observation windows that follow a reset request or a reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W    = 3;
  localparam int PRE_W    = (1 << SEL_W) - 1;
  localparam int CTRL_W   = SEL_W + 2;
  localparam int RUN_BIT  = 0;
  localparam int MODE_BIT = 1;
  localparam int SEL_LSB  = 2;

  // low-bit mask of the prescaler phase for a divide-by-2^sel
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    return ~({PRE_W{1'b1}} << sel);
  endfunction

  // the phase that ends a prescaler period
  function automatic logic phase_done(input logic [PRE_W-1:0] pre,
                                      input logic [SEL_W-1:0] sel);
    return (pre & div_mask(sel)) == div_mask(sel);
  endfunction

  // the count value whose next tick overflows
  function automatic logic at_terminal(input logic [63:0] cnt, input int width);
    return cnt == ((64'd1 << width) - 64'd1);
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic              run,
  output logic              mode,
  output logic [SEL_W-1:0]  sel
);
  logic run_q, mode_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else if (we) begin
      run_q <= run_q | wdata[RUN_BIT];
      if (!run_q) mode_q <= wdata[MODE_BIT];
      sel_q <= wdata[SEL_LSB +: SEL_W];
    end
  end

  assign run  = run_q;
  assign mode = mode_q;
  assign sel  = sel_q;

  a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |=> run_q);
  a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && we) |=> $stable(mode_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             active,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = active && !clr && phase_done(pre_q, sel);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else if (active) pre_q <= pre_q + 1'b1;
  end

  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active && !clr) |=> $stable(pre_q));
  a_r6_phase_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick,
  input  logic clr,
  input  logic mode,
  output logic ovf,
  output logic halted,
  output logic rst_req,
  output logic irq
);
  logic [CNT_W-1:0] cnt_q;
  logic halted_q, rst_req_q, irq_q;

  assign ovf = tick && at_terminal(64'(cnt_q), CNT_W);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      halted_q  <= 1'b0;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= ovf && mode;
      irq_q     <= ovf && !mode;
      if (ovf && mode) halted_q <= 1'b1;
      if (clr)         cnt_q <= '0;
      else if (ovf)    cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign halted  = halted_q;
  assign rst_req = rst_req_q;
  assign irq     = irq_q;

  a_r3_req_one_shot: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
  a_r4_stay_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    halted_q |=> halted_q);
  a_r4_no_count: assert property (@(posedge clk) disable iff (!rst_ni)
    (halted_q && !clr) |=> $stable(cnt_q));
  a_r4_no_event: assert property (@(posedge clk) disable iff (!rst_ni)
    halted_q |=> (!rst_req_q && !irq_q));
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));
  a_r8_hold_count: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !clr) |=> $stable(cnt_q));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rst_req_q && irq_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              wd_rst_n,
  input  logic              cnt_en,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic              rst_req,
  output logic              irq
);
  logic rst_ni;
  logic run, mode, halted, active, tick, ovf;
  logic [SEL_W-1:0] sel;

  wdog_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(wd_rst_n), .rst_ni(rst_ni)
  );

  wdog_ctrl_reg u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .we(cfg_we), .wdata(cfg_wdata),
    .run(run), .mode(mode), .sel(sel)
  );

  assign active = run && !halted && cnt_en;

  wdog_prescaler u_pre (
    .clk(clk), .rst_ni(rst_ni), .active(active), .clr(cfg_we),
    .sel(sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .clr(cfg_we), .mode(mode),
    .ovf(ovf), .halted(halted), .rst_req(rst_req), .irq(irq)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> (!rst_req && !irq));
  a_r9_event_source: assert property (@(posedge clk) disable iff (!rst_ni)
    (rst_req || irq) |-> $past(ovf));
  a_r10_async_clear: assert property (@(posedge clk)
    !wd_rst_n |-> (!rst_req && !irq));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int N = 5;
  localparam int P = 1 << N;

  logic clk = 1'b0;
  logic wd_rst_n = 1'b0;
  logic cnt_en = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic rst_req, irq;

  int checks = 0, failures = 0, cyc = 0, wcyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_timer #(.CNT_W(N)) u_dut (
    .clk(clk), .wd_rst_n(wd_rst_n), .cnt_en(cnt_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_sync = 0, m_phase = 0, m_ticks = 0;
  bit m_started = 0, m_reqmode = 0, m_frozen = 0, m_rst = 0, m_irq = 0;
  int m_div = 1;

  always @(posedge clk) cyc++;

  always @(posedge clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      m_sync = 0; m_phase = 0; m_ticks = 0; m_div = 1;
      m_started = 0; m_reqmode = 0; m_frozen = 0; m_rst = 0; m_irq = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      m_rst = 0; m_irq = 0;
      if (cfg_we) begin
        m_ticks = 0; m_phase = 0;
        if (!m_started) m_reqmode = cfg_wdata[1];
        if (cfg_wdata[0]) m_started = 1;
        m_div = 2 ** cfg_wdata[4:2];
      end else if (m_started && !m_frozen && cnt_en) begin
        m_phase++;
        if (m_phase == m_div) begin
          m_phase = 0;
          m_ticks++;
          if (m_ticks == P) begin
            m_ticks = 0;
            if (m_reqmode) begin m_rst = 1; m_frozen = 1; end
            else m_irq = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(rst_req === m_rst, "R3 rst_req vs model", int'(rst_req), int'(m_rst));
      check(irq === m_irq, "R9 irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    wcyc = cyc;
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    wd_rst_n = 1'b0;
    #1;
    check(rst_req === 1'b0 && irq === 1'b0, "R10 outputs clear in reset",
          int'(rst_req | irq), 0);
    repeat (3) @(negedge clk);
    wd_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // wait for an event on the chosen output; check its delay from wcyc
  task automatic expect_evt(input bit want_irq, input int delta, input string tag);
    int seen = -1;
    for (int i = 0; i < delta + 40 && seen < 0; i++) begin
      @(negedge clk);
      if ((want_irq ? irq : rst_req) === 1'b1) seen = cyc - wcyc;
    end
    check(seen == delta, tag, seen, delta);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req === 1'b1 || irq === 1'b1) hits++;
    end
    check(hits == 0, tag, hits, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
      begin
        repeat (3) @(negedge clk);
        wd_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(rst_req === 1'b0 && irq === 1'b0, "R1 reset state", int'(rst_req | irq), 0);
        expect_quiet(3 * P, "R1 no event while not started");

        // R2/R3: start in reset-request mode, divide 1
        wr(5'b000_11);
        expect_evt(0, P, "R2 R3 request after 2^N ticks");
        @(negedge clk);
        check(rst_req === 1'b0, "R3 request is one cycle", int'(rst_req), 0);
        expect_quiet(4 * P, "R4 frozen after request");
        wr(5'b000_11);
        expect_quiet(4 * P, "R4 write does not restart");

        // R7: divide by 4
        do_reset();
        wr(5'b010_11);
        expect_evt(0, 4 * P, "R7 divide-by-4 period");
        do_reset();
        wr(5'b111_11);
        expect_evt(0, 128 * P, "R7 divide-by-128 period");

        // R6: kicking prevents overflow
        do_reset();
        wr(5'b000_11);
        for (int k = 0; k < 10; k++) begin
          repeat (P - 6) @(negedge clk);
          wr(5'b000_11);
        end
        check(rst_req === 1'b0, "R6 kicks prevented request", int'(rst_req), 0);
        expect_evt(0, P, "R6 request after last write");

        // R5/R9: interrupt mode, lock of run and mode
        do_reset();
        wr(5'b000_01);
        repeat (10) @(negedge clk);
        wr(5'b000_00);
        expect_evt(1, P, "R5 clear of start bit ignored");
        wcyc = cyc;
        expect_evt(1, P, "R9 irq repeats each period");
        wr(5'b000_10);
        expect_evt(1, P, "R5 mode change ignored, still irq");
        check(rst_req === 1'b0, "R9 no request in irq mode", int'(rst_req), 0);

        // R8: pause of the tick source
        do_reset();
        wr(5'b001_11);
        repeat (7) @(negedge clk);
        cnt_en = 1'b0;
        repeat (50) @(negedge clk);
        cnt_en = 1'b1;
        expect_evt(0, 2 * P + 50, "R8 paused cycles delay request");

        // R10: reset mid-run clears run state
        wr(5'b000_11);
        do_reset();
        wr(5'b000_01);
        wr(5'b000_11);
        expect_evt(1, P, "R10 mode cleared by reset, re-writable");
        do_reset();
        expect_quiet(3 * P, "R10 run state cleared by reset");

        done = 1;
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule